// File: doc/BRIEF.md
# Counter Snapshot Capture Unit

This block keeps a single shadow copy of a bank of event counters. When a snapshot is requested, every shadow register takes the value of its counter on the same clock edge. Software can then read a consistent picture of all counters at its own pace, while the live counters keep running. The counting itself happens elsewhere. This unit only sees the live values and the overflow pulses.

A snapshot can come from three sources. The first is an external request/acknowledge handshake. The second is a software write that sets the capture bit of the control word. The third is an overflow pulse from a counter whose count enable and overflow-capture enable are both set. There is one shadow set, so every new capture replaces the previous contents. The handshake pins are synchronous to `clk`.

Top module: `snap_capture_unit`

## Requirements
- R1: After reset, every shadow register reads 0 and `snap_ack` is 0.
- R2: A capture loads every shadow register with its live counter value on the same clock edge. The values are those present on `cnt_val_flat` in the cycle the trigger is seen. Counter i occupies bits [i*CNT_W +: CNT_W] of both flat buses.
- R3: A write with `wr_en`=1, `wr_addr`=CTRL_ADDR (default 0) and bit CAPT_BIT (default 0) of `wr_data` set to 1 causes a capture. A write to another address, or one with that bit at 0, causes none.
- R4: The capture bit does not hold. One qualifying write gives exactly one capture, and later counter changes leave the shadows alone until another trigger arrives.
- R5: An overflow pulse on counter i causes a capture only when bit i of `cnt_en` and bit i of `ovf_cap_en` are both 1.
- R6: When `snap_req` is 1 while the handshake is idle (`snap_ack`=0), a capture happens on that edge and `snap_ack` reads 1 from the next cycle.
- R7: `snap_ack` stays 1 while `snap_req` stays 1. It returns to 0 on the edge after `snap_req` is seen at 0.
- R8: Holding `snap_req` at 1 after the acknowledge does not cause more captures. Only a request seen again after `snap_ack` has returned to 0 starts a new capture.
- R9: Triggers from several sources in the same cycle give one capture of that cycle's values, and the handshake still completes normally.
- R10: Each new capture overwrites the previous shadow contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_val_flat | input | NUM_CNT*CNT_W | Live counter values, flattened |
| ovf_pulse | input | NUM_CNT | One-cycle overflow pulse per counter |
| cnt_en | input | NUM_CNT | Counter enable mask |
| ovf_cap_en | input | NUM_CNT | Per-counter overflow-capture enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| snap_req | input | 1 | Handshake request |
| snap_ack | output | 1 | Handshake acknowledge |
| shadow_flat | output | NUM_CNT*CNT_W | Shadow register values, flattened |

## Verification
Counter values change every cycle, so a capture taken one cycle early or late shows up as a wrong shadow value. Overflow pulses are tried under every combination of the two masks to tell apart using the right enables, the wrong enable, or an enable taken from another counter. Writes vary the address and the capture bit, which separates decoding of the address from decoding of the bit. The handshake is run with long and short request pulses, with requests held high, and with requests that coincide with the other sources. These runs expose recapture while the request is held, early dropping of the acknowledge, and double triggering. A random phase mixes all the sources against a cycle model kept in the bench.

// File: rtl/snap_pkg.sv
package snap_pkg;
  typedef enum logic {HS_IDLE = 1'b0, HS_HOLD = 1'b1} hs_state_e;
endpackage

// File: rtl/snap_trigger.sv
module snap_trigger #(
  parameter int NUM_CNT   = 5,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int CTRL_ADDR = 0,
  parameter int CAPT_BIT  = 0
) (
  input  logic [NUM_CNT-1:0] ovf_pulse,
  input  logic [NUM_CNT-1:0] cnt_en,
  input  logic [NUM_CNT-1:0] ovf_cap_en,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               hs_start,
  output logic               sw_hit,
  output logic               ovf_hit,
  output logic               cap_fire
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  function automatic logic ovf_qualify(input logic [NUM_CNT-1:0] p,
                                       input logic [NUM_CNT-1:0] e,
                                       input logic [NUM_CNT-1:0] c);
    return |(p & e & c);
  endfunction

  function automatic logic sw_qualify(input logic we, input logic [ADDR_W-1:0] a,
                                      input logic [DATA_W-1:0] d);
    return we && (a == CTRL_A) && d[CAPT_BIT];
  endfunction

  always_comb begin
    sw_hit   = sw_qualify(wr_en, wr_addr, wr_data);
    ovf_hit  = ovf_qualify(ovf_pulse, cnt_en, ovf_cap_en);
    cap_fire = sw_hit | ovf_hit | hs_start;
  end
endmodule

// File: rtl/snap_hs_fsm.sv
module snap_hs_fsm
  import snap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic start,
  output logic ack
);
  hs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    start   = 1'b0;
    unique case (state_q)
      HS_IDLE: if (req) begin
        start   = 1'b1;
        state_d = HS_HOLD;
      end
      HS_HOLD: if (!req) state_d = HS_IDLE;
      default: state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= HS_IDLE;
    else        state_q <= state_d;
  end

  assign ack = (state_q == HS_HOLD);
endmodule

// File: rtl/snap_shadow_bank.sv
module snap_shadow_bank #(
  parameter int NUM_CNT = 5,
  parameter int CNT_W   = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [NUM_CNT*CNT_W-1:0] live,
  output logic [NUM_CNT*CNT_W-1:0] shadow
);
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_slot
    logic [CNT_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n)    slot_q <= '0;
      else if (load) slot_q <= live[i*CNT_W +: CNT_W];
    end
    assign shadow[i*CNT_W +: CNT_W] = slot_q;
  end
endmodule

// File: rtl/snap_capture_unit.sv
module snap_capture_unit #(
  parameter int NUM_CNT   = 5,
  parameter int CNT_W     = 32,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int CTRL_ADDR = 0,
  parameter int CAPT_BIT  = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CNT*CNT_W-1:0] cnt_val_flat,
  input  logic [NUM_CNT-1:0]       ovf_pulse,
  input  logic [NUM_CNT-1:0]       cnt_en,
  input  logic [NUM_CNT-1:0]       ovf_cap_en,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     snap_req,
  output logic                     snap_ack,
  output logic [NUM_CNT*CNT_W-1:0] shadow_flat
);
  logic hs_start;
  logic sw_hit;
  logic ovf_hit;
  logic cap_fire;

  snap_hs_fsm u_hs (
    .clk(clk), .rst_n(rst_n), .req(snap_req), .start(hs_start), .ack(snap_ack)
  );

  snap_trigger #(
    .NUM_CNT(NUM_CNT), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CTRL_ADDR(CTRL_ADDR), .CAPT_BIT(CAPT_BIT)
  ) u_trig (
    .ovf_pulse(ovf_pulse), .cnt_en(cnt_en), .ovf_cap_en(ovf_cap_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hs_start(hs_start), .sw_hit(sw_hit), .ovf_hit(ovf_hit), .cap_fire(cap_fire)
  );

  snap_shadow_bank #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .load(cap_fire),
    .live(cnt_val_flat), .shadow(shadow_flat)
  );
endmodule

// File: rtl/snap_capture_chk.sv
module snap_capture_chk #(
  parameter int NUM_CNT   = 5,
  parameter int CNT_W     = 32,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int CTRL_ADDR = 0,
  parameter int CAPT_BIT  = 0
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_CNT*CNT_W-1:0] cnt_val_flat,
  input logic [NUM_CNT-1:0]       ovf_pulse,
  input logic [NUM_CNT-1:0]       cnt_en,
  input logic [NUM_CNT-1:0]       ovf_cap_en,
  input logic                     wr_en,
  input logic [ADDR_W-1:0]        wr_addr,
  input logic [DATA_W-1:0]        wr_data,
  input logic                     snap_req,
  input logic                     snap_ack,
  input logic [NUM_CNT*CNT_W-1:0] shadow_flat,
  input logic                     cap_fire
);
  // R2
  all_slots_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> (shadow_flat == $past(cnt_val_flat)));
  // R4
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_fire |=> $stable(shadow_flat));
  // R3
  sw_write_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == ADDR_W'(CTRL_ADDR)) && wr_data[CAPT_BIT]) |-> cap_fire);
  // R5
  ovf_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovf_pulse & cnt_en & ovf_cap_en) != '0) |-> cap_fire);
  // R6
  ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(snap_ack) |-> ($past(snap_req) && $past(cap_fire)));
  // R7
  ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(snap_ack) |-> !$past(snap_req));
  // R7
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_ack && snap_req) |=> snap_ack);
endmodule

bind snap_capture_unit snap_capture_chk #(
  .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .CTRL_ADDR(CTRL_ADDR), .CAPT_BIT(CAPT_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_val_flat(cnt_val_flat), .ovf_pulse(ovf_pulse),
  .cnt_en(cnt_en), .ovf_cap_en(ovf_cap_en), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .snap_req(snap_req), .snap_ack(snap_ack),
  .shadow_flat(shadow_flat), .cap_fire(cap_fire)
);

// File: tb/tb_snap_capture_unit.sv
module tb_snap_capture_unit;
  localparam int N  = 5;
  localparam int W  = 32;
  localparam int AW = 4;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N*W-1:0] cnt_val_flat = '0;
  logic [N-1:0] ovf_pulse = '0, cnt_en = '0, ovf_cap_en = '0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic snap_req = 1'b0;
  logic snap_ack;
  logic [N*W-1:0] shadow_flat;

  int checks = 0, failures = 0;
  logic [N*W-1:0] m_shadow = '0;
  logic m_ack = 1'b0;
  int seed = 7;
  logic done = 1'b0;

  always #2 clk = ~clk;

  snap_capture_unit dut (
    .clk(clk), .rst_n(rst_n), .cnt_val_flat(cnt_val_flat), .ovf_pulse(ovf_pulse),
    .cnt_en(cnt_en), .ovf_cap_en(ovf_cap_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .snap_req(snap_req), .snap_ack(snap_ack), .shadow_flat(shadow_flat)
  );

  function automatic logic want_capture(logic ack_now, logic req, logic we,
                                        logic [AW-1:0] a, logic [DW-1:0] d,
                                        logic [N-1:0] p, logic [N-1:0] e, logic [N-1:0] c);
    logic any_ovf = 1'b0;
    for (int i = 0; i < N; i++) if (p[i] && e[i] && c[i]) any_ovf = 1'b1;
    return (!ack_now && req) || (we && a == 0 && d[0]) || any_ovf;
  endfunction

  task automatic chk(string tag, logic [N*W-1:0] act, logic [N*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fresh_counts();
    for (int i = 0; i < N; i++) cnt_val_flat[i*W +: W] = $urandom();
  endtask

  // advance one cycle, update model, compare at the following falling edge
  task automatic tick(string tag);
    if (want_capture(m_ack, snap_req, wr_en, wr_addr, wr_data, ovf_pulse, cnt_en, ovf_cap_en))
      m_shadow = cnt_val_flat;
    if (!m_ack && snap_req) m_ack = 1'b1;
    else if (m_ack && !snap_req) m_ack = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " shadow"}, shadow_flat, m_shadow);
    chk({tag, " ack"}, {{(N*W-1){1'b0}}, snap_ack}, {{(N*W-1){1'b0}}, m_ack});
    wr_en = 1'b0; ovf_pulse = '0;
    fresh_counts();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 shadow", shadow_flat, '0);
    chk("R1 ack", {{(N*W-1){1'b0}}, snap_ack}, '0);
    fresh_counts();
    tick("R4 idle no capture");
    // R3 software write captures; R2 all slots
    wr_en = 1; wr_addr = 0; wr_data = 32'h1; tick("R3 R2 sw capture");
    wr_en = 1; wr_addr = 3; wr_data = 32'h1; tick("R3 wrong address");
    wr_en = 1; wr_addr = 0; wr_data = 32'hFFFF_FFFE; tick("R3 bit clear");
    // R4 self clearing: counters change without a trigger
    tick("R4 no repeat"); tick("R4 no repeat 2");
    // R5 overflow mask combinations
    for (int k = 0; k < 4; k++) begin
      ovf_pulse = 5'b00100; cnt_en = (k & 1) ? 5'b00100 : 5'b11011;
      ovf_cap_en = (k & 2) ? 5'b00100 : 5'b11011; tick("R5 ovf masks");
    end
    ovf_pulse = 5'b00001; cnt_en = 5'b00010; ovf_cap_en = 5'b00001; tick("R5 cross mask");
    // R6 R7 R8 handshake with held request
    snap_req = 1; tick("R6 req capture");
    for (int k = 0; k < 4; k++) tick("R8 held req");
    snap_req = 0; tick("R7 ack fall");
    tick("R7 idle");
    // R8 quick re-request right after ack fell; R10 overwrite
    snap_req = 1; tick("R10 R8 second handshake");
    snap_req = 0; tick("R7 short");
    snap_req = 1; tick("R8 immediate re-request");
    snap_req = 0; tick("R7 drop");
    // R9 coincident triggers
    snap_req = 1; wr_en = 1; wr_addr = 0; wr_data = 1;
    ovf_pulse = 5'b10000; cnt_en = 5'b10000; ovf_cap_en = 5'b10000; tick("R9 coincident");
    tick("R9 after"); snap_req = 0; tick("R9 handshake ends"); tick("R9 idle");
    // random mix
    for (int k = 0; k < 3000; k++) begin
      snap_req   = ($urandom_range(0, 3) != 0) ? snap_req : ~snap_req;
      wr_en      = ($urandom_range(0, 7) == 0);
      wr_addr    = AW'($urandom_range(0, 2));
      wr_data    = $urandom();
      ovf_pulse  = ($urandom_range(0, 3) == 0) ? N'($urandom()) : '0;
      cnt_en     = N'($urandom());
      ovf_cap_en = N'($urandom());
      tick("R2 R10 random");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule